// File: doc/BRIEF.md
# Parallel Display Bus Write Engine

This block performs single-byte writes on an 8080-style parallel bus toward a display controller. A requester offers one byte together with a type bit. The type bit selects an index write, which carries a register address, or a parameter write, which carries data for the register last indexed. The engine accepts the request through a valid/ready handshake and then walks the bus pins through three timed phases:

- assert the control group;
- present the byte;
- release the control group.

Each phase lasts `HOLD_CYCLES` clocks, so the bus never toggles faster than the external controller can follow.

The four control pins form one group. Their order, from most to least significant, is chip select, read strobe, write strobe and register select, all of which except register select are active low. When a write opens, the group takes 0100 for an index write or 0101 for a parameter write. The byte is placed on the bus one hold period later. One further hold period later, chip select and write strobe rise together, which gives 1110 or 1111. The rising write strobe is the point where the controller latches the byte. After a final recovery period the engine pulses a one-clock completion flag and becomes ready again.

Top module: `pbus_write_engine`

## Requirements
- R1: While reset is asserted, and until the internal synchronised reset releases, `req_ready` and `wr_done` are low, `cs_n`, `rd_n` and `wr_n` are high, and `rs` and `bus_data` are 0. A few clocks after reset release, `req_ready` is high.
- R2: A request is taken only on a clock edge where `req_valid` and `req_ready` are both high. Requests offered while `req_ready` is low do not change the bus, the pins or the handshake.
- R3: On the accepting edge, the control group {cs_n, rd_n, wr_n, rs} becomes 0,1,0,T, where T is `req_type` (0 = index write, 1 = parameter write). During the first `HOLD_CYCLES` clocks of the write, `bus_data` keeps its previous value.
- R4: Exactly `HOLD_CYCLES` clocks after the accepting edge, `bus_data` takes the accepted byte. The control group is unchanged.
- R5: Exactly 2·`HOLD_CYCLES` clocks after the accepting edge, `cs_n` and `wr_n` rise on the same edge. `bus_data` and `rs` hold steady across that edge, so the group reads 1,1,1,T.
- R6: `rd_n` is high in every cycle.
- R7: Exactly 3·`HOLD_CYCLES` clocks after the accepting edge, `wr_done` is high for one clock. `req_ready` stays low from the accepting edge until one clock after that pulse, and then rises.
- R8: While idle, `cs_n` and `wr_n` are high, and `bus_data` and `rs` hold the values of the last write.
- R9: A request that is held valid when `req_ready` rises is accepted on the very next edge, so writes can run back to back with a period of 3·`HOLD_CYCLES`+2 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_valid | input | 1 | A write request is offered |
| req_ready | output | 1 | Engine can accept a request this cycle |
| req_data | input | DATA_W | Byte to write |
| req_type | input | 1 | 0 = index write, 1 = parameter write |
| wr_done | output | 1 | One-clock pulse at the end of a write |
| bus_data | output | DATA_W | Parallel data bus |
| cs_n | output | 1 | Chip select, active low |
| rd_n | output | 1 | Read strobe, held high |
| wr_n | output | 1 | Write strobe, active low; the byte is latched on its rising edge |
| rs | output | 1 | Register select: low for index, high for parameter |

## Verification
The bench builds the engine with `DATA_W` = 8 and `HOLD_CYCLES` = 3. The short hold keeps every write to eleven clocks, which makes it cheap to run every byte value under both write types back to back, with each cycle of each write compared against an arithmetic timeline. Every fifth write has a conflicting request held on the inputs while the engine is busy. Idle gaps are inserted regularly so that the hold-last-value behaviour of the bus and register select is observed between writes.

// File: rtl/pbus_write_pkg.sv
package pbus_write_pkg;

  // Write progress through the bus cycle.
  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_SETUP   = 3'd1,
    PH_DRIVE   = 3'd2,
    PH_RELEASE = 3'd3,
    PH_DONE    = 3'd4
  } phase_e;

  // Control pin group; member order is the order the controller sees.
  typedef struct packed {
    logic cs_n;
    logic rd_n;
    logic wr_n;
    logic rs;
  } ctl_grp_t;

  function automatic ctl_grp_t grp_open(input logic is_param);
    ctl_grp_t g;
    g.cs_n = 1'b0;
    g.rd_n = 1'b1;
    g.wr_n = 1'b0;
    g.rs   = is_param;
    return g;
  endfunction

  function automatic ctl_grp_t grp_close(input logic is_param);
    ctl_grp_t g;
    g.cs_n = 1'b1;
    g.rd_n = 1'b1;
    g.wr_n = 1'b1;
    g.rs   = is_param;
    return g;
  endfunction

endpackage

// File: rtl/pbus_reset_sync.sv
module pbus_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/pbus_hold_timer.sv
module pbus_hold_timer #(
  parameter int HOLD_CYCLES = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic expired
);

  localparam int CW = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(HOLD_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    if (load) cnt_d = RELOAD;
    else      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

  // R4: each phase counts down one step per clock until it expires
  a_r4_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R4: a loaded timer never reports expiry on the next cycle unless hold is 1
  a_r4_load_value: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == RELOAD));

endmodule

// File: rtl/pbus_phase_seq.sv
module pbus_phase_seq
  import pbus_write_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   expired,
  output phase_e phase_q,
  output phase_e phase_d,
  output logic   timer_load,
  output logic   done,
  output logic   idle
);

  always_comb begin
    phase_d    = phase_q;
    timer_load = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (start) begin
          phase_d    = PH_SETUP;
          timer_load = 1'b1;
        end
      end
      PH_SETUP: begin
        if (expired) begin
          phase_d    = PH_DRIVE;
          timer_load = 1'b1;
        end
      end
      PH_DRIVE: begin
        if (expired) begin
          phase_d    = PH_RELEASE;
          timer_load = 1'b1;
        end
      end
      PH_RELEASE: begin
        if (expired) phase_d = PH_DONE;
      end
      PH_DONE: phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

  assign done = (phase_q == PH_DONE);
  assign idle = (phase_q == PH_IDLE);

  // R7: completion lasts exactly one clock and is followed by idle
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && idle));

  // R7: a write leaves idle only through setup
  a_r7_enter_setup: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && start) |=> (phase_q == PH_SETUP));

endmodule

// File: rtl/pbus_pin_driver.sv
module pbus_pin_driver
  import pbus_write_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_e            phase_q,
  input  phase_e            phase_d,
  input  logic [DATA_W-1:0] req_data,
  input  logic              req_type,
  output logic [DATA_W-1:0] bus_data,
  output ctl_grp_t          ctl
);

  logic [DATA_W-1:0] byte_q;
  logic [DATA_W-1:0] bus_q;
  ctl_grp_t          ctl_q;
  ctl_grp_t          ctl_d;
  logic              take_req;
  logic              put_byte;
  logic              ctl_en;

  always_comb begin
    take_req = (phase_q == PH_IDLE)  && (phase_d == PH_SETUP);
    put_byte = (phase_q == PH_SETUP) && (phase_d == PH_DRIVE);
    ctl_en   = take_req || ((phase_q == PH_DRIVE) && (phase_d == PH_RELEASE));
    if (take_req) ctl_d = grp_open(req_type);
    else          ctl_d = grp_close(ctl_q.rs);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        byte_q <= '0;
    else if (take_req) byte_q <= req_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        bus_q <= '0;
    else if (put_byte) bus_q <= byte_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= grp_close(1'b0);
    else if (ctl_en) ctl_q <= ctl_d;
  end

  assign bus_data = bus_q;
  assign ctl      = ctl_q;

  // R5: the byte is steady across the write strobe rising edge
  a_r5_bus_stable_at_latch: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_q.wr_n) |-> ($stable(bus_q) && $stable(ctl_q.rs)));

  // R5: chip select and write strobe rise on the same edge
  a_r5_cs_with_wr: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_q.wr_n) |-> $rose(ctl_q.cs_n));

  // R4: the bus changes only while chip select is low
  a_r4_bus_inside_select: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bus_q) |-> !ctl_q.cs_n);

endmodule

// File: rtl/pbus_write_engine.sv
module pbus_write_engine
  import pbus_write_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int HOLD_CYCLES = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [DATA_W-1:0] req_data,
  input  logic              req_type,
  output logic              wr_done,
  output logic [DATA_W-1:0] bus_data,
  output logic              cs_n,
  output logic              rd_n,
  output logic              wr_n,
  output logic              rs
);

  logic     srst_n;
  logic     start;
  logic     expired;
  logic     timer_load;
  logic     seq_idle;
  phase_e   phase_q;
  phase_e   phase_d;
  ctl_grp_t ctl;

  pbus_reset_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  pbus_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_timer (
    .clk     (clk),
    .rst_n   (srst_n),
    .load    (timer_load),
    .expired (expired)
  );

  pbus_phase_seq u_seq (
    .clk        (clk),
    .rst_n      (srst_n),
    .start      (start),
    .expired    (expired),
    .phase_q    (phase_q),
    .phase_d    (phase_d),
    .timer_load (timer_load),
    .done       (wr_done),
    .idle       (seq_idle)
  );

  pbus_pin_driver #(.DATA_W(DATA_W)) u_pins (
    .clk      (clk),
    .rst_n    (srst_n),
    .phase_q  (phase_q),
    .phase_d  (phase_d),
    .req_data (req_data),
    .req_type (req_type),
    .bus_data (bus_data),
    .ctl      (ctl)
  );

  assign req_ready = seq_idle && srst_n;
  assign start     = req_valid && req_ready;
  assign cs_n      = ctl.cs_n;
  assign rd_n      = ctl.rd_n;
  assign wr_n      = ctl.wr_n;
  assign rs        = ctl.rs;

  // R3: an accepted request opens the group with the requested select level
  a_r3_open_group: assert property (@(posedge clk) disable iff (!srst_n)
    (req_valid && req_ready) |=> (!cs_n && !wr_n && rd_n && (rs == $past(req_type))));

  // R2: no handshake while the strobe is active
  a_r2_busy_not_ready: assert property (@(posedge clk) disable iff (!srst_n)
    !wr_n |-> !req_ready);

  // R8: an idle cycle without a request leaves bus and select untouched
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!srst_n)
    (req_ready && !req_valid) |=> ($stable(bus_data) && $stable(rs) && cs_n && wr_n));

  // R7: ready returns exactly one clock after completion
  a_r7_ready_after_done: assert property (@(posedge clk) disable iff (!srst_n)
    wr_done |=> req_ready);

endmodule

// File: tb/pbus_write_engine_bench.sv
module pbus_write_engine_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DW         = 8;
  localparam int HOLD       = 3;
  localparam int SPAN       = 3 * HOLD + 1;

  logic          clk;
  logic          rst_n;
  logic          req_valid;
  logic          req_ready;
  logic [DW-1:0] req_data;
  logic          req_type;
  logic          wr_done;
  logic [DW-1:0] bus_data;
  logic          cs_n;
  logic          rd_n;
  logic          wr_n;
  logic          rs;

  int n_checks;
  int n_fails;
  logic [DW-1:0] last_b;
  logic          last_t;

  pbus_write_engine #(.DATA_W(DW), .HOLD_CYCLES(HOLD)) u_pbus_write_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_data  (req_data),
    .req_type  (req_type),
    .wr_done   (wr_done),
    .bus_data  (bus_data),
    .cs_n      (cs_n),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .rs        (rs)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // packed view: ready, done, cs_n, rd_n, wr_n, rs, bus
  function automatic logic [DW+5:0] pins();
    return {req_ready, wr_done, cs_n, rd_n, wr_n, rs, bus_data};
  endfunction

  task automatic cmp(input string req, input logic [DW+5:0] act, input logic [DW+5:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
  endtask

  // one write; starts and ends at a falling edge
  task automatic do_write(input logic [DW-1:0] b, input logic t, input logic noise);
    logic [DW-1:0] prev;
    prev = last_b;
    cmp("R9 ready before request", {5'b0, req_ready, {DW{1'b0}}}, {5'b0, 1'b1, {DW{1'b0}}});
    req_valid = 1'b1;
    req_data  = b;
    req_type  = t;
    @(posedge clk);
    for (int j = 0; j <= SPAN; j++) begin
      logic [DW+5:0] e;
      string tag;
      @(negedge clk);
      if (j == 0) begin
        if (noise) begin
          req_data = ~b;
          req_type = ~t;
        end else begin
          req_valid = 1'b0;
        end
      end
      if (j == 3 * HOLD) req_valid = 1'b0;
      e = {(j == SPAN), (j == 3 * HOLD), (j >= 2 * HOLD), 1'b1, (j >= 2 * HOLD), t,
           (j >= HOLD) ? b : prev};
      if (j < HOLD)          tag = "R3 open";
      else if (j < 2 * HOLD) tag = "R4 drive";
      else if (j < 3 * HOLD) tag = "R5 release";
      else                   tag = "R7 done/ready";
      cmp($sformatf("%s%s R6 cycle %0d byte %h type %0d", tag, noise ? " R2 busy-request" : "",
                    j, b, t), pins(), e);
    end
    last_b = b;
    last_t = t;
  endtask

  task automatic idle_check(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      cmp("R8 idle hold", pins(), {1'b1, 1'b0, 1'b1, 1'b1, 1'b1, last_t, last_b});
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog R7: actual no completion expected run end");
    summary();
    $finish;
  end

  initial begin
    n_checks  = 0;
    n_fails   = 0;
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_data  = '0;
    req_type  = 1'b0;
    last_b    = '0;
    last_t    = 1'b0;
    repeat (3) @(negedge clk);
    cmp("R1 R6 in reset", pins(), {1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, {DW{1'b0}}});
    rst_n = 1'b1;
    @(negedge clk);
    cmp("R1 sync release pending", pins(), {1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, {DW{1'b0}}});
    repeat (3) @(negedge clk);
    cmp("R1 ready after release", pins(), {1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, {DW{1'b0}}});
    idle_check(2);

    for (int t = 0; t < 2; t++) begin
      for (int b = 0; b < (1 << DW); b++) begin
        do_write(b[DW-1:0], t[0], (b % 5) == 2);
        if ((b % 37) == 0) idle_check(3);
      end
    end
    idle_check(4);

    summary();
    $finish;
  end

endmodule